// File: doc/BRIEF.md
# Stack Transfer Instruction Sequencer

This block carries out the single-byte stack transfer instructions of a small 8-bit processor core. It owns the accumulator, the two index registers, the flag byte, the stack pointer and a 16-bit program counter. The surrounding core hands it one opcode with a start strobe, and the block performs the instruction against a byte-wide synchronous memory port. It reports completion with a one-cycle done pulse.

Eight opcodes are understood. Four copy a register onto the stack, and four load a register from it. The stack lives in a fixed memory page, and the stack pointer wraps within that page. Pushes store first and then decrement. Pulls increment first and then load. Loading A, X or Y updates the negative and zero flags. Loading the flag byte forces three of its bits high. Any other opcode is reported as illegal after a single cycle and leaves all state untouched.

Cycles are counted from the clock edge that samples start: the instruction occupies the next N cycles, and done is high during the last of them. New register values are visible from the cycle after done.

Top module: `stk_seq`

## Requirements
- R1: Opcodes are decoded as follows. 0x48, 0x08, 0xDA and 0x5A push A, P, X and Y. 0x68, 0x28, 0xFA and 0x7A pull A, P, X and Y.
- R2: A push drives mem_addr = 0x0100 + SP with the source register on mem_wdata and asserts mem_we for exactly one cycle. SP then drops by one.
- R3: A pull first raises SP by one and then reads the byte at 0x0100 + new SP. mem_rdata is valid one cycle after the address is presented.
- R4: done is a single-cycle pulse. For a push it comes in the 3rd cycle after the start edge, and for a pull in the 4th.
- R5: Every legal instruction adds exactly 1 to the 16-bit PC, with carry into the upper byte.
- R6: A push changes none of A, X, Y or P, and pushing P stores the flag byte unchanged.
- R7: A pull into A, X or Y sets P bit 1 (Z) when the byte is zero and P bit 7 (N) from bit 7 of the byte, and clears each otherwise. All other P bits and the other registers hold their values.
- R8: A pull into P loads the byte with bits 5, 4 and 2 forced to 1.
- R9: SP wraps modulo 256. A pull at SP = 0xFF reads 0x0100 and leaves SP = 0x00, and a push at SP = 0x00 writes 0x0100 and leaves SP = 0xFF.
- R10: Any other opcode raises illegal together with done in the 1st cycle after the start edge. It writes no memory and changes no register.
- R11: start is ignored while an instruction is in progress.
- R12: After reset, A = X = Y = 0, SP = RST_SP (0xFF), P = RST_P (0x34) and PC = RST_PC. done, illegal and mem_we are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the instruction given on opcode |
| opcode | input | 8 | Instruction byte |
| mem_addr | output | 16 | Memory address, always in the stack page |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| done | output | 1 | Instruction complete |
| illegal | output | 1 | Opcode not supported (with done) |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | Index X |
| reg_y | output | 8 | Index Y |
| reg_p | output | 8 | Flag byte |
| reg_sp | output | 8 | Stack pointer |
| reg_pc | output | 16 | Program counter |

## Verification
The hardest case to reach is the stack pointer wrapping in both directions, together with a program counter carry into its upper byte. The registers can be loaded only through pulls, and the stack pointer moves only by one per instruction. The bench therefore resets with SP at 0xFF and overrides the reset PC to 0x01FE. Its first pull then wraps SP to 0x00 and reads 0x0100, and the push that follows wraps SP back to 0xFF. Those same two instructions carry the PC across 0x0200. Register values for the later checks are planted by pulling bytes that the bench first writes into its memory model.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam logic [7:0] OP_PUSH_A = 8'h48;
    localparam logic [7:0] OP_PUSH_P = 8'h08;
    localparam logic [7:0] OP_PUSH_X = 8'hDA;
    localparam logic [7:0] OP_PUSH_Y = 8'h5A;
    localparam logic [7:0] OP_PULL_A = 8'h68;
    localparam logic [7:0] OP_PULL_P = 8'h28;
    localparam logic [7:0] OP_PULL_X = 8'hFA;
    localparam logic [7:0] OP_PULL_Y = 8'h7A;

    // flag bit positions
    localparam int FB_N = 7;
    localparam int FB_U = 5;
    localparam int FB_B = 4;
    localparam int FB_I = 2;
    localparam int FB_Z = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_WR,
        ST_PUSH_DEC,
        ST_PULL_INC,
        ST_PULL_ADR,
        ST_PULL_DAT,
        ST_FIN,
        ST_ILL
    } st_e;

    typedef enum logic [1:0] {
        TGT_A,
        TGT_P,
        TGT_X,
        TGT_Y
    } tgt_e;

    typedef struct packed {
        logic legal;
        logic is_pull;
        tgt_e tgt;
    } dec_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
(
    input  logic [7:0] op,
    output dec_t       dec
);
    always_comb begin
        dec = '{legal: 1'b1, is_pull: 1'b0, tgt: TGT_A};
        case (op)
            OP_PUSH_A: dec.tgt = TGT_A;
            OP_PUSH_P: dec.tgt = TGT_P;
            OP_PUSH_X: dec.tgt = TGT_X;
            OP_PUSH_Y: dec.tgt = TGT_Y;
            OP_PULL_A: begin dec.is_pull = 1'b1; dec.tgt = TGT_A; end
            OP_PULL_P: begin dec.is_pull = 1'b1; dec.tgt = TGT_P; end
            OP_PULL_X: begin dec.is_pull = 1'b1; dec.tgt = TGT_X; end
            OP_PULL_Y: begin dec.is_pull = 1'b1; dec.tgt = TGT_Y; end
            default:   dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/stk_src_mux.sv
module stk_src_mux
    import stk_pkg::*;
#(
    parameter int DW = 8
) (
    input  tgt_e          sel,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] p,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] q
);
    always_comb begin
        case (sel)
            TGT_A:   q = a;
            TGT_P:   q = p;
            TGT_X:   q = x;
            default: q = y;
        endcase
    end
endmodule

// File: rtl/stk_flags.sv
module stk_flags
    import stk_pkg::*;
#(
    parameter int DW = 8
) (
    input  tgt_e          tgt,
    input  logic [DW-1:0] p_in,
    input  logic [DW-1:0] byte_in,
    output logic [DW-1:0] p_out
);
    localparam logic [DW-1:0] FORCE_MASK =
        DW'((1 << FB_U) | (1 << FB_B) | (1 << FB_I));

    always_comb begin
        p_out = p_in;
        if (tgt == TGT_P) begin
            p_out = byte_in | FORCE_MASK;
        end else begin
            p_out[FB_N] = byte_in[DW-1];
            p_out[FB_Z] = (byte_in == '0);
        end
    end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [7:0]  RST_SP     = 8'hFF,
    parameter logic [7:0]  RST_P      = 8'h34,
    parameter logic [15:0] RST_PC     = 16'h0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  opcode,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    input  logic [7:0]  mem_rdata,
    output logic        done,
    output logic        illegal,
    output logic [7:0]  reg_a,
    output logic [7:0]  reg_x,
    output logic [7:0]  reg_y,
    output logic [7:0]  reg_p,
    output logic [7:0]  reg_sp,
    output logic [15:0] reg_pc
);
    localparam int DW   = 8;
    localparam int PC_W = 16;

    typedef struct packed {
        st_e             st;
        logic            is_pull;
        tgt_e            tgt;
        logic [DW-1:0]   a;
        logic [DW-1:0]   x;
        logic [DW-1:0]   y;
        logic [DW-1:0]   p;
        logic [DW-1:0]   sp;
        logic [PC_W-1:0] pc;
        logic [DW-1:0]   dlat;
    } state_t;

    state_t s_q, s_d;
    dec_t   dec_w;
    logic [DW-1:0] push_src_w;
    logic [DW-1:0] p_new_w;

    stk_decode u_dec (
        .op  (opcode),
        .dec (dec_w)
    );

    stk_src_mux #(.DW(DW)) u_src (
        .sel (s_q.tgt),
        .a   (s_q.a),
        .p   (s_q.p),
        .x   (s_q.x),
        .y   (s_q.y),
        .q   (push_src_w)
    );

    stk_flags #(.DW(DW)) u_flg (
        .tgt     (s_q.tgt),
        .p_in    (s_q.p),
        .byte_in (s_q.dlat),
        .p_out   (p_new_w)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (dec_w.legal) begin
                        s_d.is_pull = dec_w.is_pull;
                        s_d.tgt     = dec_w.tgt;
                        s_d.st      = dec_w.is_pull ? ST_PULL_INC : ST_PUSH_WR;
                    end else begin
                        s_d.st = ST_ILL;
                    end
                end
            end
            ST_PUSH_WR:  s_d.st = ST_PUSH_DEC;
            ST_PUSH_DEC: begin
                s_d.sp = s_q.sp - 8'd1;
                s_d.st = ST_FIN;
            end
            ST_PULL_INC: begin
                s_d.sp = s_q.sp + 8'd1;
                s_d.st = ST_PULL_ADR;
            end
            ST_PULL_ADR: s_d.st = ST_PULL_DAT;
            ST_PULL_DAT: begin
                s_d.dlat = mem_rdata;
                s_d.st   = ST_FIN;
            end
            ST_FIN: begin
                s_d.pc = s_q.pc + 16'd1;
                if (s_q.is_pull) begin
                    s_d.p = p_new_w;
                    case (s_q.tgt)
                        TGT_A:   s_d.a = s_q.dlat;
                        TGT_X:   s_d.x = s_q.dlat;
                        TGT_Y:   s_d.y = s_q.dlat;
                        default: ;
                    endcase
                end
                s_d.st = ST_IDLE;
            end
            ST_ILL:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, is_pull: 1'b0, tgt: TGT_A,
                     a: '0, x: '0, y: '0, p: RST_P, sp: RST_SP,
                     pc: RST_PC, dlat: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr  = {STACK_PAGE, s_q.sp};
    assign mem_wdata = push_src_w;
    assign mem_we    = (s_q.st == ST_PUSH_WR);
    assign done      = (s_q.st == ST_FIN) || (s_q.st == ST_ILL);
    assign illegal   = (s_q.st == ST_ILL);
    assign reg_a     = s_q.a;
    assign reg_x     = s_q.x;
    assign reg_y     = s_q.y;
    assign reg_p     = s_q.p;
    assign reg_sp    = s_q.sp;
    assign reg_pc    = s_q.pc;

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        done,
    input logic        illegal,
    input logic [7:0]  reg_sp,
    input logic [7:0]  reg_p,
    input logic [15:0] reg_pc
);
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);                                            // R2
    AST_WE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[15:8] == 8'h01);                            // R2
    AST_SP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ##2 (reg_sp == 8'($past(reg_sp, 2) - 8'd1)));        // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                // R4
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |=> reg_pc == 16'($past(reg_pc) + 16'd1));   // R5
    AST_ILL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);                                              // R10
    AST_ILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(reg_sp) && $stable(reg_pc) && $stable(reg_p)); // R10
    AST_P_FORCED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_p[5] && reg_p[4] && reg_p[2]);                              // R8
endmodule

bind stk_seq stk_seq_chk u_chk (.*);

// File: tb/sim_stk_seq.sv
`timescale 1ns/1ps
module sim_stk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic        done, illegal;
    logic [7:0]  reg_a, reg_x, reg_y, reg_p, reg_sp;
    logic [15:0] reg_pc;

    int checks = 0;
    int errors = 0;

    logic [7:0] e_a, e_x, e_y, e_p, e_sp;
    logic [15:0] e_pc;

    logic       tb_we = 1'b0;
    logic [7:0] tb_adr = 8'h00;
    logic [7:0] tb_dat = 8'h00;
    logic [7:0] smem [256];

    always #4 clk = ~clk;

    stk_seq #(.RST_PC(16'h01FE)) u0 (.*);

    always @(posedge clk) begin
        if (mem_we) smem[mem_addr[7:0]] <= mem_wdata;
        else if (tb_we) smem[tb_adr] <= tb_dat;
        mem_rdata <= smem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] nz(input logic [7:0] p, input logic [7:0] v);
        return (p & 8'h7D) | {v[7], 5'b0, (v == 8'h00), 1'b0};
    endfunction

    task automatic poke(input logic [7:0] adr, input logic [7:0] dat);
        @(negedge clk); tb_we = 1'b1; tb_adr = adr; tb_dat = dat;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic run(input logic [7:0] op, output int cyc, output int wes, output logic ill);
        @(negedge clk); start = 1'b1; opcode = op;
        cyc = 0; wes = 0; ill = 1'b0;
        @(negedge clk); start = 1'b0;
        forever begin
            cyc++;
            if (mem_we) wes++;
            if (done) begin ill = illegal; break; end
            if (cyc > 20) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic regs(input string req);
        chk(reg_a == e_a, req, reg_a, e_a);
        chk(reg_x == e_x, req, reg_x, e_x);
        chk(reg_y == e_y, req, reg_y, e_y);
        chk(reg_p == e_p, req, reg_p, e_p);
        chk(reg_sp == e_sp, req, reg_sp, e_sp);
        chk(reg_pc == e_pc, req, reg_pc, e_pc);
    endtask

    task automatic t_reset();
        e_a = 0; e_x = 0; e_y = 0; e_p = 8'h34; e_sp = 8'hFF; e_pc = 16'h01FE;
        regs("R12");
        chk(!done && !illegal && !mem_we, "R12", {13'b0, done, illegal, mem_we}, 16'h0);
    endtask

    task automatic pull(input logic [7:0] op, input logic [7:0] v, input string req);
        int c, w; logic il;
        logic [7:0] nsp;
        nsp = e_sp + 8'd1;
        poke(nsp, v);
        run(op, c, w, il);
        e_sp = nsp; e_pc = e_pc + 16'd1;
        case (op)
            8'h68: begin e_a = v; e_p = nz(e_p, v); end
            8'hFA: begin e_x = v; e_p = nz(e_p, v); end
            8'h7A: begin e_y = v; e_p = nz(e_p, v); end
            default: e_p = v | 8'h34;
        endcase
        chk(c == 4, "R4 pull cycles", 16'(c), 16'd4);
        chk(w == 0 && !il, "R3 pull no write", 16'(w), 16'd0);
        regs(req);
    endtask

    task automatic push(input logic [7:0] op, input logic [7:0] src, input string req);
        int c, w; logic il;
        logic [7:0] at;
        at = e_sp;
        poke(at, ~src);
        run(op, c, w, il);
        e_sp = e_sp - 8'd1; e_pc = e_pc + 16'd1;
        chk(c == 3, "R4 push cycles", 16'(c), 16'd3);
        chk(w == 1, "R2 one write", 16'(w), 16'd1);
        chk(smem[at] == src, req, {8'h0, smem[at]}, {8'h0, src});
        regs("R6");
    endtask

    task automatic t_wrap();
        pull(8'h68, 8'h9C, "R9 pull wrap");
        chk(reg_sp == 8'h00, "R9 sp", reg_sp, 16'h0);
        push(8'h48, 8'h9C, "R9 push wrap 0x0100");
        chk(reg_sp == 8'hFF && reg_pc == 16'h0200, "R5 pc carry", reg_pc, 16'h0200);
    endtask

    task automatic t_pulls();
        pull(8'h68, 8'h00, "R7 pull A zero");
        pull(8'h68, 8'h45, "R7 pull A plain");
        pull(8'hFA, 8'h80, "R7 pull X neg");
        pull(8'h7A, 8'h3B, "R7 pull Y");
        pull(8'h7A, 8'h00, "R7 pull Y zero");
        pull(8'h28, 8'h00, "R8 pull P zero");
        pull(8'h28, 8'hC3, "R8 pull P pattern");
        pull(8'h68, 8'hF1, "R1 pull A");
    endtask

    task automatic t_pushes();
        push(8'h48, e_a, "R1 R2 push A");
        push(8'hDA, e_x, "R1 push X");
        push(8'h5A, e_y, "R1 push Y");
        push(8'h08, e_p, "R6 push P as is");
    endtask

    task automatic t_illegal();
        foreach (ill_ops[i]) begin
            int c, w; logic il;
            run(ill_ops[i], c, w, il);
            chk(c == 1 && il, "R10 illegal 1 cycle", 16'(c), 16'd1);
            chk(w == 0, "R10 no write", 16'(w), 16'd0);
            regs("R10");
        end
    endtask
    logic [7:0] ill_ops [3] = '{8'h00, 8'hEA, 8'h49};

    task automatic t_busy();
        int n;
        @(negedge clk); start = 1'b1; opcode = 8'h48;
        @(negedge clk); opcode = 8'hFF;
        n = 0;
        for (int k = 1; k <= 8; k++) begin
            if (done) begin
                n++;
                chk(k == 3 && !illegal, "R11 done only for first", 16'(k), 16'd3);
            end
            if (k == 2) start = 1'b0;
            @(negedge clk);
        end
        chk(n == 1, "R11 one done", 16'(n), 16'd1);
        e_sp = e_sp - 8'd1; e_pc = e_pc + 16'd1;
        regs("R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) smem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_pulls();
        t_pushes();
        t_illegal();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule